// File: doc/BRIEF.md
# Interleaved Shared-RAM Bus Timing Generator

This block derives the two quadrature processor bus clocks, E and Q, from a master clock. It also splits every machine cycle between a CPU and a video display generator that share one RAM. The first half of each cycle belongs to the video side, which receives a one-quarter-cycle fetch strobe. The second half belongs to the CPU, whose data strobe covers the final quarter. Because each master owns a fixed slot, neither one ever waits.

A speed bit selects between a normal cycle of `SLOW_DIV` master clocks and a fast cycle of half that length. The CPU sets the bit by writing to one address and clears it by writing to another. A fast cycle is issued only under two conditions:

- the speed bit is set, and
- either the upcoming access targets ROM, or horizontal or field sync is asserted (active low), meaning video is blanking and will not touch RAM.

The cycle length is chosen only at a cycle boundary, so E and Q never produce runt pulses. Fast cycles carry no video fetch.

Top module: `shared_ram_timer`

## Requirements
- R1: In every cycle, `ramCpu` is low in quarters 0–1 and high in quarters 2–3. `cpuStrobe` is high exactly in quarter 3.
- R2: A normal cycle lasts `SLOW_DIV` (16) master clocks, split into four equal quarters. `qClk` is high in quarters 1–2 and `eClk` is high in quarters 2–3, so Q leads E by one quarter. Every output reflects the phase counter one master clock later.
- R3: A fast cycle lasts `SLOW_DIV/2` (8) master clocks and has the same quarter shape, with each quarter halved.
- R4: The next cycle is fast only if, on the master-clock edge that ends the current cycle, both of these hold:
  - the speed bit is 1, and
  - either `accClass` equals 2'b01 (ROM; 2'b00 is RAM, 2'b10 is I/O) or `hsN`/`fsN` is 0.
  Otherwise the next cycle is normal.
- R5: `vidStrobe` is high exactly in quarter 1 of normal cycles and never during fast cycles.
- R6: A clock edge with `cpuWr`=1 and `cpuAddr`=`FAST_ADDR` sets the speed bit. One with `cpuAddr`=`SLOW_ADDR` clears it. A write to any other address leaves it unchanged.
- R7: The cycle length changes only at a cycle boundary, so every E period is exactly 8 or 16 master clocks.
- R8: After reset all outputs are low, the speed bit is clear, and the first cycle is normal.
- R9: `vidStrobe` and `cpuStrobe` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Asynchronous active-low reset |
| accClass | input | 2 | Class of the upcoming CPU access: 00 RAM, 01 ROM, 10 I/O |
| hsN | input | 1 | Horizontal sync, active low |
| fsN | input | 1 | Field sync, active low |
| cpuWr | input | 1 | CPU write qualifier for the speed-bit addresses |
| cpuAddr | input | ADDR_W | CPU address |
| eClk | output | 1 | Bus clock E |
| qClk | output | 1 | Quadrature bus clock Q |
| ramCpu | output | 1 | RAM owner select: 1 = CPU, 0 = video |
| vidStrobe | output | 1 | Video fetch strobe |
| cpuStrobe | output | 1 | CPU data strobe |

## Verification
A phase counter that is off by even one state moves every edge of E, Q and the owner select, so the reference comparison catches it within one clock. A wrong fast decision or a stale speed bit lengthens or shortens the next E period. That shows up at the next falling edge of E, at most 16 clocks later. The stimulus exercises all of these cases:

- ROM accesses while video is active;
- RAM and I/O accesses under each sync;
- writes to unrelated addresses;
- class changes in the middle of a cycle, which must have no effect before the boundary.

// File: rtl/timing_pkg.sv
package timing_pkg;
  typedef enum logic [1:0] {
    ACC_RAM = 2'b00,
    ACC_ROM = 2'b01,
    ACC_IO  = 2'b10
  } accClass_e;

  // phase information handed from control to the output datapath
  typedef struct packed {
    logic [1:0] quarter;
    logic       fast;
  } phaseCtl_t;
endpackage

// File: rtl/timing_ctrl.sv
module timing_ctrl
  import timing_pkg::*;
#(
  parameter int SLOW_DIV = 16,
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] SLOW_ADDR = 16'hFF40,
  parameter logic [ADDR_W-1:0] FAST_ADDR = 16'hFF41
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        accClass,
  input  logic              hsN,
  input  logic              fsN,
  input  logic              cpuWr,
  input  logic [ADDR_W-1:0] cpuAddr,
  output phaseCtl_t         phase
);
  localparam int CNT_W = $clog2(SLOW_DIV);
  localparam logic [CNT_W-1:0] SLOW_LAST = CNT_W'(SLOW_DIV - 1);
  localparam logic [CNT_W-1:0] FAST_LAST = CNT_W'(SLOW_DIV / 2 - 1);

  logic [CNT_W-1:0] cnt;
  logic             fastCyc;
  logic             speedBit;
  logic             lastTick;
  logic             blanking;
  logic             nextFast;

  assign lastTick = (cnt == (fastCyc ? FAST_LAST : SLOW_LAST));
  assign blanking = !hsN || !fsN;
  assign nextFast = speedBit && ((accClass == ACC_ROM) || blanking);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      speedBit <= 1'b0;
    end else if (cpuWr && cpuAddr == FAST_ADDR) begin
      speedBit <= 1'b1;
    end else if (cpuWr && cpuAddr == SLOW_ADDR) begin
      speedBit <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt     <= '0;
      fastCyc <= 1'b0;
    end else if (lastTick) begin
      cnt     <= '0;
      fastCyc <= nextFast;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign phase.fast    = fastCyc;
  assign phase.quarter = fastCyc ? cnt[CNT_W-2 -: 2] : cnt[CNT_W-1 -: 2];

  // R4: a fast cycle only starts when the speed bit was set at the boundary
  a_r4_fast_needs_speed: assert property (@(posedge clk) disable iff (!rstN)
    (cnt == '0 && fastCyc) |-> $past(speedBit));

  // R7: the cycle length changes only where a new cycle begins
  a_r7_switch_at_boundary: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(fastCyc) |-> (cnt == '0));
endmodule

// File: rtl/timing_outputs.sv
module timing_outputs
  import timing_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  phaseCtl_t phase,
  output logic      eClk,
  output logic      qClk,
  output logic      ramCpu,
  output logic      vidStrobe,
  output logic      cpuStrobe
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      eClk      <= 1'b0;
      qClk      <= 1'b0;
      ramCpu    <= 1'b0;
      vidStrobe <= 1'b0;
      cpuStrobe <= 1'b0;
    end else begin
      qClk      <= (phase.quarter == 2'd1) || (phase.quarter == 2'd2);
      eClk      <= phase.quarter[1];
      ramCpu    <= phase.quarter[1];
      vidStrobe <= (phase.quarter == 2'd1) && !phase.fast;
      cpuStrobe <= (phase.quarter == 2'd3);
    end
  end

  a_r9_no_overlap: assert property (@(posedge clk) disable iff (!rstN)
    !(vidStrobe && cpuStrobe));

  a_r1_cpu_strobe_owns_ram: assert property (@(posedge clk) disable iff (!rstN)
    cpuStrobe |-> ramCpu);

  a_r2_q_leads_e: assert property (@(posedge clk) disable iff (!rstN)
    $rose(eClk) |-> qClk);

  a_r5_vid_in_video_half: assert property (@(posedge clk) disable iff (!rstN)
    vidStrobe |-> (!ramCpu && qClk));
endmodule

// File: rtl/shared_ram_timer.sv
module shared_ram_timer
  import timing_pkg::*;
#(
  parameter int SLOW_DIV = 16,
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] SLOW_ADDR = 16'hFF40,
  parameter logic [ADDR_W-1:0] FAST_ADDR = 16'hFF41
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        accClass,
  input  logic              hsN,
  input  logic              fsN,
  input  logic              cpuWr,
  input  logic [ADDR_W-1:0] cpuAddr,
  output logic              eClk,
  output logic              qClk,
  output logic              ramCpu,
  output logic              vidStrobe,
  output logic              cpuStrobe
);
  phaseCtl_t phase;

  timing_ctrl #(
    .SLOW_DIV (SLOW_DIV),
    .ADDR_W   (ADDR_W),
    .SLOW_ADDR(SLOW_ADDR),
    .FAST_ADDR(FAST_ADDR)
  ) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .accClass(accClass),
    .hsN     (hsN),
    .fsN     (fsN),
    .cpuWr   (cpuWr),
    .cpuAddr (cpuAddr),
    .phase   (phase)
  );

  timing_outputs uOut (
    .clk      (clk),
    .rstN     (rstN),
    .phase    (phase),
    .eClk     (eClk),
    .qClk     (qClk),
    .ramCpu   (ramCpu),
    .vidStrobe(vidStrobe),
    .cpuStrobe(cpuStrobe)
  );
endmodule

// File: tb/tb_shared_ram_timer.sv
module tb_shared_ram_timer;
  localparam logic [15:0] SLOW_A = 16'hFF40;
  localparam logic [15:0] FAST_A = 16'hFF41;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] accClass = 2'b00;
  logic hsN = 1'b1;
  logic fsN = 1'b1;
  logic cpuWr = 1'b0;
  logic [15:0] cpuAddr = 16'h0000;
  logic eClk, qClk, ramCpu, vidStrobe, cpuStrobe;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  shared_ram_timer dut (
    .clk(clk), .rstN(rstN), .accClass(accClass), .hsN(hsN), .fsN(fsN),
    .cpuWr(cpuWr), .cpuAddr(cpuAddr), .eClk(eClk), .qClk(qClk),
    .ramCpu(ramCpu), .vidStrobe(vidStrobe), .cpuStrobe(cpuStrobe)
  );

  // expected output item: {q, e, ramCpu, vid, cpu}
  logic [4:0] expQ[$];

  task automatic check(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s at %0t: actual=%0d expected=%0d", tag, $time, act, exp);
    end
  endtask

  // reference model, built from the requirements, pushes expected items
  int  mCnt = 0;
  bit  mFast = 1'b0;
  bit  mSpeed = 1'b0;
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mCnt = 0; mFast = 1'b0; mSpeed = 1'b0;
      expQ.delete();
    end else begin
      int len;
      int qtr;
      len = mFast ? 8 : 16;
      qtr = mCnt / (len / 4);
      expQ.push_back({(qtr == 1 || qtr == 2), (qtr >= 2), (qtr >= 2),
                      (qtr == 1 && !mFast), (qtr == 3)});
      if (mCnt == len - 1) begin
        mCnt = 0;
        mFast = mSpeed && (accClass == 2'b01 || !hsN || !fsN);
      end else begin
        mCnt++;
      end
      if (cpuWr && cpuAddr == FAST_A) mSpeed = 1'b1;
      else if (cpuWr && cpuAddr == SLOW_A) mSpeed = 1'b0;
    end
  end

  // monitor: pops and compares, measures E periods
  int  ePeriod = 0;
  bit  eSeen = 1'b0;
  bit  prevE = 1'b0;
  int  fastSeen = 0;
  always @(negedge clk) begin
    if (rstN && expQ.size() > 0) begin
      logic [4:0] ex;
      ex = expQ.pop_front();
      check("R2 qClk", qClk, ex[4]);
      check("R2 eClk", eClk, ex[3]);
      check("R1 ramCpu", ramCpu, ex[2]);
      check("R5 vidStrobe", vidStrobe, ex[1]);
      check("R1 cpuStrobe", cpuStrobe, ex[0]);
      check("R9 strobe overlap", int'(vidStrobe && cpuStrobe), 0);
      ePeriod++;
      if (prevE && !eClk) begin
        if (eSeen) begin
          check("R7 E period legal", int'(ePeriod == 8 || ePeriod == 16), 1);
          if (ePeriod == 8) fastSeen++;
        end
        eSeen = 1'b1;
        ePeriod = 0;
      end
      prevE = eClk;
    end
  end

  task automatic waitClk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic writeAddr(input logic [15:0] a);
    @(negedge clk);
    cpuWr = 1'b1; cpuAddr = a;
    @(negedge clk);
    cpuWr = 1'b0; cpuAddr = 16'h0000;
  endtask

  initial begin
    int f0;
    waitClk(3);
    // R8: reset state at the ports
    check("R8 reset eClk", eClk, 0);
    check("R8 reset qClk", qClk, 0);
    check("R8 reset ramCpu", ramCpu, 0);
    check("R8 reset strobes", int'(vidStrobe || cpuStrobe), 0);
    rstN = 1'b1;
    waitClk(64);
    // R4: ROM without the speed bit stays normal
    accClass = 2'b01;
    f0 = fastSeen;
    waitClk(64);
    check("R4 no fast without speed bit", fastSeen - f0, 0);
    // R6: a write to another address has no effect
    writeAddr(16'hFF42);
    f0 = fastSeen;
    waitClk(64);
    check("R6 unrelated write ignored", fastSeen - f0, 0);
    // R6/R3: set the speed bit, ROM goes fast
    writeAddr(FAST_A);
    f0 = fastSeen;
    waitClk(64);
    check("R3 ROM cycles fast", int'(fastSeen - f0 > 2), 1);
    // R4: RAM with video active stays normal
    accClass = 2'b00;
    waitClk(20);
    f0 = fastSeen;
    waitClk(64);
    check("R4 RAM active video normal", fastSeen - f0, 0);
    // R4: RAM during horizontal sync and field sync goes fast
    hsN = 1'b0;
    f0 = fastSeen;
    waitClk(64);
    check("R4 RAM in hsync fast", int'(fastSeen - f0 > 2), 1);
    hsN = 1'b1; fsN = 1'b0; accClass = 2'b10;
    f0 = fastSeen;
    waitClk(64);
    check("R4 IO in fsync fast", int'(fastSeen - f0 > 2), 1);
    fsN = 1'b1;
    // R7: class toggling mid-cycle, checked by scoreboard
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      accClass = 2'($urandom_range(0, 2));
      hsN = ($urandom_range(0, 7) != 0);
      fsN = ($urandom_range(0, 15) != 0);
    end
    // R6: clearing the bit returns to normal even for ROM
    accClass = 2'b01; hsN = 1'b1; fsN = 1'b1;
    writeAddr(SLOW_A);
    waitClk(20);
    f0 = fastSeen;
    waitClk(64);
    check("R6 cleared speed normal", fastSeen - f0, 0);
    waitClk(8);
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule